// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a virtual page to a physical page by searching a hashed page table held in ordinary memory. A request carries the virtual segment identifier of the segment being accessed, the 28-bit address within that segment, and a flag saying whether the access is a store. The walker hashes the segment identifier with the page index to choose a group of eight table entries, reads them one at a time through a single-word request/acknowledge memory port, and stops at the first entry whose tag matches. If the first group holds no match, it hashes again with the complemented hash, picks a second group, and searches that one for entries marked as secondary.

On a hit the walker marks the entry as referenced and, for stores, as modified. It writes the second word of the entry back only when one of those two status bits actually changes. It then reports the physical address, both words of the entry, and a write-grant flag. The flag is withheld on loads, so the first store to a clean page comes back through the walker and sets the modified bit. The table base and group mask are software-programmable inputs. Access rights and fault reporting belong to the surrounding logic.

Top module: `hpt_walker`

## Requirements
- R1: The group address is `tbl_base + ((H << 6) & tbl_mask)`, computed modulo 2^32, where H is the 32-bit value `{8'b0, seg_vsid} ^ {16'b0, va_off[27:12]}` for the first pass and its one's complement `~H` for the second pass.
- R2: Within a group, entry i sits at byte offset `8*i`, with its first word at +0 and its second word at +4. The first words are read in increasing i. The search stops at the first match, and that entry's second word is read next.
- R3: A first word W matches only when all of these hold: W[31] (valid) is 1, W[6] (secondary flag) equals the pass number (0 first, 1 second), W[30:7] equals `seg_vsid`, and W[5:0] equals `va_off[27:22]`.
- R4: When no entry of the first group matches, the second group, chosen with the complemented hash, is searched in the same way.
- R5: When neither group matches, the walker reads exactly 16 first words and no second word, writes nothing, and raises `done` with `hit` low.
- R6: On a hit, `pa` is `{W1[31:12], va_off[11:0]}`. `pte_hi` returns the first word, and `pte_lo` returns the second word with its status bits updated.
- R7: On a hit, bit 8 of the second word (referenced) is set, and bit 7 (modified) is also set for stores. The word is written back only if its value changed; otherwise no memory write occurs.
- R8: `wr_grant` is 1 only with a hit for a store access, and is 0 for every load result.
- R9: A request presented while `busy` is high is ignored. It neither alters the walk in progress nor starts another walk.
- R10: `done` is a one-cycle pulse issued with `busy` low. While `mem_req` waits for `mem_ack`, the address, write enable and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk (taken only while idle) |
| req_store | input | 1 | Access is a store |
| seg_vsid | input | 24 | Virtual segment identifier |
| va_off | input | 28 | Address within the segment |
| tbl_base | input | 32 | Byte base address of the table |
| tbl_mask | input | 32 | Mask applied to the scaled hash |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result pulse |
| hit | output | 1 | Entry found (valid with done) |
| pa | output | 32 | Physical address |
| pte_hi | output | 32 | First word of the entry |
| pte_lo | output | 32 | Updated second word of the entry |
| wr_grant | output | 1 | Write may be cached for this page |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed, read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench uses the default eight-entry group and 32-bit addressing. It sets a 64 KiB table window with `tbl_mask` = 0x0000FFC0 and `tbl_base` = 0x00010000, so both hash passes land inside a 128 KiB model memory and any group can be computed independently in the bench. The model memory's acknowledge latency is varied from 0 to 3 idle cycles, which exercises the hold-until-acknowledge rule and back-to-back word reads. Counting reads and writes in the model checks the scan order, the exact miss cost and the skipping of unneeded write-backs.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int VSID_W    = 24;
  localparam int VOFF_W    = 28;
  localparam int PIDX_W    = 16;
  localparam int API_W     = 6;
  localparam int PAGE_BITS = 12;
  localparam int WORD_W    = 32;
  localparam int W0_VALID  = 31;
  localparam int W0_SEC    = 6;
  localparam int W1_REF    = 8;
  localparam int W1_CHG    = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_RD0,
    ST_RD1,
    ST_WB
  } walk_state_t;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRP_SHIFT = 6
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pidx,
  input  logic              secondary,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] grp_addr,
  output logic [VSID_W+API_W-1:0] tag
);
  localparam int WIDE_W = ADDR_W + WORD_W;

  logic [WORD_W-1:0] hash_pri;
  logic [WORD_W-1:0] hash_sel;
  logic [WIDE_W-1:0] scaled;

  always_comb begin
    hash_pri = {{(WORD_W-VSID_W){1'b0}}, vsid} ^ {{(WORD_W-PIDX_W){1'b0}}, pidx};
    hash_sel = secondary ? ~hash_pri : hash_pri;
    scaled   = {{ADDR_W{1'b0}}, hash_sel} << GRP_SHIFT;
    grp_addr = base + (scaled[ADDR_W-1:0] & mask);
    tag      = {vsid, pidx[PIDX_W-1 -: API_W]};
  end
endmodule

// File: rtl/hpt_match.sv
module hpt_match
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0]       word0,
  input  logic [VSID_W+API_W-1:0] tag,
  input  logic                    pass,
  output logic                    match
);
  logic [VSID_W+API_W-1:0] entry_tag;

  always_comb begin
    entry_tag = {word0[W0_VALID-1:W0_SEC+1], word0[W0_SEC-1:0]};
    match     = word0[W0_VALID] && (word0[W0_SEC] == pass) && (entry_tag == tag);
  end
endmodule

// File: rtl/hpt_rc_update.sv
module hpt_rc_update
  import hpt_pkg::*;
(
  input  logic [WORD_W-1:0] word1,
  input  logic              store,
  output logic [WORD_W-1:0] word1_new,
  output logic              changed
);
  always_comb begin
    word1_new         = word1;
    word1_new[W1_REF] = 1'b1;
    if (store) word1_new[W1_CHG] = 1'b1;
    changed = (word1_new != word1);
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int GROUP_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [VSID_W-1:0] seg_vsid,
  input  logic [VOFF_W-1:0] va_off,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [ADDR_W-1:0] tbl_mask,
  output logic              busy,
  output logic              done,
  output logic              hit,
  output logic [WORD_W-1:0] pa,
  output logic [WORD_W-1:0] pte_hi,
  output logic [WORD_W-1:0] pte_lo,
  output logic              wr_grant,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata
);
  localparam int ENTRY_BYTES = 2 * (WORD_W / 8);
  localparam int ENT_SHIFT   = $clog2(ENTRY_BYTES);
  localparam int GRP_SHIFT   = $clog2(GROUP_ENTRIES * ENTRY_BYTES);
  localparam int IDX_W       = $clog2(GROUP_ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);
  localparam int W1_OFF      = WORD_W / 8;

  walk_state_t state;
  logic [VSID_W-1:0] vsid_q;
  logic [VOFF_W-1:0] voff_q;
  logic              store_q;
  logic              pass_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] grp_q;
  logic [WORD_W-1:0] w0_q;
  logic [WORD_W-1:0] w1_new_q;

  logic [ADDR_W-1:0]        grp_addr;
  logic [VSID_W+API_W-1:0]  tag;
  logic                     match;
  logic [WORD_W-1:0]        w1_new;
  logic                     w1_changed;
  logic [IDX_W-1:0]         idx_nxt;
  logic [ADDR_W-1:0]        next_entry_addr;
  logic                     ack_now;

  hpt_hash #(.ADDR_W(ADDR_W), .GRP_SHIFT(GRP_SHIFT)) u_hash (
    .vsid      (vsid_q),
    .pidx      (voff_q[VOFF_W-1:PAGE_BITS]),
    .secondary (pass_q),
    .base      (tbl_base),
    .mask      (tbl_mask),
    .grp_addr  (grp_addr),
    .tag       (tag)
  );

  hpt_match u_match (
    .word0 (mem_rdata),
    .tag   (tag),
    .pass  (pass_q),
    .match (match)
  );

  hpt_rc_update u_rc (
    .word1     (mem_rdata),
    .store     (store_q),
    .word1_new (w1_new),
    .changed   (w1_changed)
  );

  always_comb begin
    idx_nxt         = idx_q + 1'b1;
    next_entry_addr = grp_q + {{(ADDR_W-IDX_W-ENT_SHIFT){1'b0}}, idx_nxt, {ENT_SHIFT{1'b0}}};
    ack_now         = mem_req && mem_ack;
    busy            = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      vsid_q    <= '0;
      voff_q    <= '0;
      store_q   <= 1'b0;
      pass_q    <= 1'b0;
      idx_q     <= '0;
      grp_q     <= '0;
      w0_q      <= '0;
      w1_new_q  <= '0;
      done      <= 1'b0;
      hit       <= 1'b0;
      pa        <= '0;
      pte_hi    <= '0;
      pte_lo    <= '0;
      wr_grant  <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done <= 1'b0;
      if (ack_now) mem_req <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            vsid_q  <= seg_vsid;
            voff_q  <= va_off;
            store_q <= req_store;
            pass_q  <= 1'b0;
            state   <= ST_START;
          end
        end
        ST_START: begin
          grp_q    <= grp_addr;
          mem_addr <= grp_addr;
          mem_we   <= 1'b0;
          mem_req  <= 1'b1;
          idx_q    <= '0;
          state    <= ST_RD0;
        end
        ST_RD0: begin
          if (ack_now) begin
            if (match) begin
              w0_q     <= mem_rdata;
              mem_addr <= mem_addr + ADDR_W'(W1_OFF);
              mem_req  <= 1'b1;
              state    <= ST_RD1;
            end else if (idx_q != LAST_IDX) begin
              idx_q    <= idx_nxt;
              mem_addr <= next_entry_addr;
              mem_req  <= 1'b1;
            end else if (!pass_q) begin
              pass_q <= 1'b1;
              state  <= ST_START;
            end else begin
              done     <= 1'b1;
              hit      <= 1'b0;
              wr_grant <= 1'b0;
              state    <= ST_IDLE;
            end
          end
        end
        ST_RD1: begin
          if (ack_now) begin
            w1_new_q <= w1_new;
            if (w1_changed) begin
              mem_we    <= 1'b1;
              mem_wdata <= w1_new;
              mem_req   <= 1'b1;
              state     <= ST_WB;
            end else begin
              done     <= 1'b1;
              hit      <= 1'b1;
              pa       <= {mem_rdata[WORD_W-1:PAGE_BITS], voff_q[PAGE_BITS-1:0]};
              pte_hi   <= w0_q;
              pte_lo   <= w1_new;
              wr_grant <= store_q;
              state    <= ST_IDLE;
            end
          end
        end
        ST_WB: begin
          if (ack_now) begin
            mem_we   <= 1'b0;
            done     <= 1'b1;
            hit      <= 1'b1;
            pa       <= {w1_new_q[WORD_W-1:PAGE_BITS], voff_q[PAGE_BITS-1:0]};
            pte_hi   <= w0_q;
            pte_lo   <= w1_new_q;
            wr_grant <= store_q;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: an outstanding request keeps its address, direction and data
  assert_req_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: write grant only for a store that hit
  assert_grant_store_R8: assert property (@(posedge clk) disable iff (rst)
    (done && wr_grant) |-> (hit && store_q));

  // R7: any write carries the referenced bit and follows a second-word read
  assert_wb_ref_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[W1_REF]);

  assert_wb_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> ($past(state) == ST_RD1));

  // R2: word-aligned accesses
  assert_addr_align_R2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R3: a reported hit has a valid first word for the requested segment
  assert_hit_valid_R3: assert property (@(posedge clk) disable iff (rst)
    (done && hit) |-> (pte_hi[W0_VALID] && (pte_hi[W0_VALID-1:W0_SEC+1] == vsid_q)));
endmodule

// File: tb/test_hpt_walker.sv
module test_hpt_walker;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] MASK = 32'h0000_FFC0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [23:0] seg_vsid = '0;
  logic [27:0] va_off = '0;
  logic        busy, done, hit, wr_grant;
  logic [31:0] pa, pte_hi, pte_lo;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int errors = 0;
  int checks = 0;
  int lat = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;
  int cnt = 0;
  logic        bw_en = 1'b0;
  logic [31:0] bw_addr = '0;
  logic [31:0] bw_data = '0;
  logic [31:0] mem [0:32767];

  logic        r_hit, r_grant;
  logic [31:0] r_pa, r_hi, r_lo;

  always #5 clk = ~clk;

  hpt_walker i_hpt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .seg_vsid(seg_vsid), .va_off(va_off), .tbl_base(BASE), .tbl_mask(MASK),
    .busy(busy), .done(done), .hit(hit), .pa(pa), .pte_hi(pte_hi),
    .pte_lo(pte_lo), .wr_grant(wr_grant), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // memory model with variable acknowledge latency
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      cnt <= 0;
      for (int i = 0; i < 32768; i++) mem[i] <= '0;
    end else begin
      if (bw_en) mem[bw_addr[16:2]] <= bw_data;
      if (mem_ack) begin
        mem_ack <= 1'b0;
        cnt <= 0;
      end else if (mem_req) begin
        if (cnt >= lat) begin
          mem_ack <= 1'b1;
          if (mem_we) begin
            mem[mem_addr[16:2]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
          end else begin
            mem_rdata <= mem[mem_addr[16:2]];
            rd_cnt <= rd_cnt + 1;
          end
        end else begin
          cnt <= cnt + 1;
        end
      end
    end
  end

  function automatic logic [31:0] grp(input logic [23:0] v, input logic [27:0] o, input logic sec);
    logic [31:0] h;
    h = {8'b0, v} ^ {16'b0, o[27:12]};
    if (sec) h = ~h;
    return BASE + ((h << 6) & MASK);
  endfunction

  function automatic logic [31:0] w0(input logic [23:0] v, input logic [27:0] o, input logic sec);
    return {1'b1, v, sec, o[27:22]};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bw_en = 1'b1; bw_addr = a; bw_data = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic clear_groups(input logic [23:0] v, input logic [27:0] o);
    for (int i = 0; i < 16; i++) put(grp(v, o, 1'b0) + 32'(i * 4), 32'h0);
    for (int i = 0; i < 16; i++) put(grp(v, o, 1'b1) + 32'(i * 4), 32'h0);
  endtask

  task automatic walk(input logic [23:0] v, input logic [27:0] o, input logic st);
    int n;
    @(negedge clk);
    req_valid = 1'b1; seg_vsid = v; va_off = o; req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 2000, "R10 done seen", 32'(n), 32'd0);
    r_hit = hit; r_pa = pa; r_hi = pte_hi; r_lo = pte_lo; r_grant = wr_grant;
    chk(!busy, "R10 busy low with done", {31'b0, busy}, 32'd0);
  endtask

  task automatic test_reset;
    chk(!busy && !done && !mem_req, "R10 reset idle",
        {29'b0, busy, done, mem_req}, 32'd0);
  endtask

  // R1 R2 R6 R7: load hit at entry 3 of the first group, write-back, reuse, store
  task automatic test_primary;
    logic [23:0] v; logic [27:0] o; logic [31:0] e, w1; int rd0, wr0;
    v = 24'hABCDE1; o = 28'h234_5678; lat = 1;
    clear_groups(v, o);
    e = grp(v, o, 1'b0) + 32'd24;
    w1 = 32'h0ABC_D002;
    put(e, w0(v, o, 1'b0)); put(e + 4, w1);
    rd0 = rd_cnt; wr0 = wr_cnt;
    walk(v, o, 1'b0);
    chk(r_hit, "R1 primary hit", {31'b0, r_hit}, 32'd1);
    chk(r_pa == 32'h0ABC_D678, "R6 pa", r_pa, 32'h0ABC_D678);
    chk(r_hi == w0(v, o, 1'b0), "R6 pte_hi", r_hi, w0(v, o, 1'b0));
    chk(r_lo == (w1 | 32'h100), "R7 ref set", r_lo, w1 | 32'h100);
    chk(rd_cnt - rd0 == 5, "R2 scan reads", 32'(rd_cnt - rd0), 32'd5);
    chk(wr_cnt - wr0 == 1, "R7 one write", 32'(wr_cnt - wr0), 32'd1);
    chk(mem[e[16:2] + 1] == (w1 | 32'h100), "R7 memory ref", mem[e[16:2] + 1], w1 | 32'h100);
    chk(!r_grant, "R8 load no grant", {31'b0, r_grant}, 32'd0);
    wr0 = wr_cnt; lat = 0;
    walk(v, o, 1'b0);
    chk(wr_cnt == wr0, "R7 no write when unchanged", 32'(wr_cnt - wr0), 32'd0);
    chk(r_hit && r_lo == (w1 | 32'h100), "R7 unchanged word", r_lo, w1 | 32'h100);
    wr0 = wr_cnt; lat = 2;
    walk(v, o, 1'b1);
    chk(wr_cnt - wr0 == 1, "R7 store write", 32'(wr_cnt - wr0), 32'd1);
    chk(mem[e[16:2] + 1] == (w1 | 32'h180), "R7 memory changed bit", mem[e[16:2] + 1], w1 | 32'h180);
    chk(r_grant, "R8 store grant", {31'b0, r_grant}, 32'd1);
  endtask

  // R3 R4: wrong-pass entries skipped; found in second group
  task automatic test_secondary;
    logic [23:0] v; logic [27:0] o; logic [31:0] g1, g2; int rd0;
    v = 24'h13579B; o = 28'hFED_C321; lat = 0;
    clear_groups(v, o);
    g1 = grp(v, o, 1'b0); g2 = grp(v, o, 1'b1);
    put(g1, w0(v, o, 1'b1)); put(g1 + 4, 32'h1111_1000);
    put(g2, w0(v, o, 1'b0)); put(g2 + 4, 32'h2222_2000);
    put(g2 + 16, w0(v, o, 1'b1)); put(g2 + 20, 32'h3333_3000);
    rd0 = rd_cnt;
    walk(v, o, 1'b0);
    chk(r_hit, "R4 secondary hit", {31'b0, r_hit}, 32'd1);
    chk(r_pa == 32'h3333_3321, "R3 R4 secondary pa", r_pa, 32'h3333_3321);
    chk(rd_cnt - rd0 == 12, "R4 reads", 32'(rd_cnt - rd0), 32'd12);
  endtask

  // R5 R3: miss, including an invalid entry with a matching tag
  task automatic test_miss;
    logic [23:0] v; logic [27:0] o; int rd0, wr0;
    v = 24'h00F00D; o = 28'h0C0_0ABC; lat = 3;
    clear_groups(v, o);
    put(grp(v, o, 1'b0) + 8, w0(v, o, 1'b0) & 32'h7FFF_FFFF);
    put(grp(v, o, 1'b0) + 40, {w0(v, o, 1'b0)} ^ 32'h0000_0001);
    rd0 = rd_cnt; wr0 = wr_cnt;
    walk(v, o, 1'b1);
    chk(!r_hit, "R5 miss", {31'b0, r_hit}, 32'd0);
    chk(rd_cnt - rd0 == 16, "R5 sixteen reads", 32'(rd_cnt - rd0), 32'd16);
    chk(wr_cnt == wr0, "R5 no write", 32'(wr_cnt - wr0), 32'd0);
    chk(!r_grant, "R8 miss no grant", {31'b0, r_grant}, 32'd0);
  endtask

  // R2: first match wins
  task automatic test_first_match;
    logic [23:0] v; logic [27:0] o; logic [31:0] g;
    v = 24'h5A5A5A; o = 28'h777_7010; lat = 1;
    clear_groups(v, o);
    g = grp(v, o, 1'b0);
    put(g + 8, w0(v, o, 1'b0)); put(g + 12, 32'h4444_4180);
    put(g + 40, w0(v, o, 1'b0)); put(g + 44, 32'h5555_5000);
    walk(v, o, 1'b1);
    chk(r_pa == 32'h4444_4010, "R2 first match", r_pa, 32'h4444_4010);
    chk(r_lo == 32'h4444_4180, "R7 already set", r_lo, 32'h4444_4180);
  endtask

  // R9: request during a walk is ignored
  task automatic test_busy_ignore;
    logic [23:0] v; logic [27:0] o; logic [31:0] g; int n, rd0, dn;
    v = 24'h0C0FFE; o = 28'h100_0FA0; lat = 3;
    clear_groups(v, o);
    g = grp(v, o, 1'b0);
    put(g + 16, w0(v, o, 1'b0)); put(g + 20, 32'h6666_6100);
    @(negedge clk);
    req_valid = 1'b1; seg_vsid = v; va_off = o; req_store = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (4) @(negedge clk);
    req_valid = 1'b1; seg_vsid = 24'h999999; va_off = 28'h0FF_F555; req_store = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done && pa == 32'h6666_6FA0, "R9 first walk result", pa, 32'h6666_6FA0);
    chk(!wr_grant, "R9 first walk kind", {31'b0, wr_grant}, 32'd0);
    rd0 = rd_cnt; dn = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (done || busy) dn++;
    end
    chk(dn == 0 && rd_cnt == rd0, "R9 no second walk", 32'(dn), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_primary();
    test_secondary();
    test_miss();
    test_first_match();
    test_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule